// File: doc/BRIEF.md
# Test-Fixture Rail Sequencing Controller

This controller owns the enables of the supply rails that feed a device under test on a test fixture. On a start request from the test sequencer it powers the rails up one at a time in a fixed order: the core rail first, then the I/O rail, and the RF rail last. Each rail waits for the power-good comparator of the rail below it. Once every rail reports good, the controller holds a settle dwell and then grants measurement permission. On a stop request it releases the rails in the opposite order, with a fixed settle gap between steps.

Safety inputs override everything outside the idle phase. An open chamber door or any overvoltage or overcurrent comparator flag clears every rail enable at the next clock edge and returns the machine to idle. The same happens when a rail fails to report good within a programmable number of cycles. Each of these events latches a sticky fault code that names the cause and the offending rail. That code blocks further starts until the sequencer clears it while idle.

The block sees only digitised comparator flags. It carries no data stream, so every pin is a plain level-sensitive control or status signal, sampled on the rising clock edge.

Top module: `pwrseq_ctrl`

## Requirements
- R1: The phase output encodes idle=0, precharge=1, on=2, measure=3 and ramp-down=4. A start moves idle to precharge. When the last rail reports good, precharge moves to on. After SETTLE cycles in on, the phase becomes measure.
- R2: Rails are indexed 0 (core) to N_RAILS-1 (RF), and rail_en is always a thermometer code that grows from bit 0. Rail 0 is enabled one cycle after an accepted start. Rail k+1 is enabled one cycle after pgood[k] is sampled high while rail k is the top enabled rail.
- R3: measure_ok is high only in the measure phase, and only while every rail enable is high.
- R4: If door_closed is low in any phase other than idle, the next edge clears all rail enables, enters idle and latches fault cause 1 (door) with rail field 0. A door that is open while idle raises no fault.
- R5: If any ov_flag or oc_flag bit is high outside idle, the next edge clears all rail enables and enters idle. It latches cause 2 (overvoltage) or cause 3 (overcurrent) with the rail field set to the lowest flagged rail. The door takes priority over overvoltage, and overvoltage over overcurrent. Flags seen while idle are ignored.
- R6: If the top enabled rail does not report good within pg_timeout clock edges of its enable rising, the controller clears all enables, enters idle and latches cause 4 (timeout) with that rail's index.
- R7: A stop in precharge, on or measure drops the top enabled rail at the next edge. Each remaining rail is then dropped SETTLE cycles after the previous one, and the phase returns to idle on the edge that drops rail 0.
- R8: A latched fault code (cause 0 means none) holds its value until fault_clr is sampled high in the idle phase, which resets it to 0.
- R9: A start request is ignored while a fault is latched or while door_closed is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Sequencer request to power up |
| stop_req | input | 1 | Sequencer request to power down |
| fault_clr | input | 1 | Clears the latched fault code while idle |
| door_closed | input | 1 | Chamber door interlock, high when closed |
| pgood | input | N_RAILS | Per-rail power-good comparator flags |
| ov_flag | input | N_RAILS | Per-rail overvoltage comparator flags |
| oc_flag | input | N_RAILS | Per-rail overcurrent comparator flags |
| pg_timeout | input | TO_W | Cycles each rail may take to report good (at least 1) |
| rail_en | output | N_RAILS | Per-rail enables, bit 0 is the core rail |
| measure_ok | output | 1 | Measurement permitted |
| phase | output | 3 | Current phase code |
| fault_cause | output | 3 | Latched fault cause |
| fault_rail | output | RW | Rail index of the latched fault |

## Verification
Every response to a sampled input appears one clock edge later. This covers each enable step, every safety shutdown, start rejection and fault clearing. Two kinds of result depend on counted delays. Measurement is granted SETTLE edges after the on phase is entered, and ramp-down steps fall SETTLE edges apart. A timeout fault lands pg_timeout edges after its rail's enable rises. The bench drives inputs on the falling edge and files each expected snapshot in a scoreboard tagged with the exact cycle count at which it is due, computed from these delays. A monitor compares the snapshot on the falling edge of that cycle, so both the early and the late side of each delay are pinned.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE      = 3'd0,
    PH_PRECHARGE = 3'd1,
    PH_ON        = 3'd2,
    PH_MEASURE   = 3'd3,
    PH_RAMPDOWN  = 3'd4
  } phase_e;

  typedef enum logic [2:0] {
    FC_NONE    = 3'd0,
    FC_DOOR    = 3'd1,
    FC_OVERV   = 3'd2,
    FC_OVERC   = 3'd3,
    FC_TIMEOUT = 3'd4
  } cause_e;

endpackage

// File: rtl/pwrseq_trip_arb.sv
module pwrseq_trip_arb
  import pwrseq_pkg::*;
#(
  parameter int N_RAILS = 3,
  parameter int RW      = 2
) (
  input  logic               door_closed,
  input  logic [N_RAILS-1:0] ov_flag,
  input  logic [N_RAILS-1:0] oc_flag,
  output logic               trip,
  output cause_e             trip_cause,
  output logic [RW-1:0]      trip_rail
);

  logic [RW-1:0] ov_idx;
  logic [RW-1:0] oc_idx;

  // lowest flagged rail wins: scan downward so the last hit is the lowest
  always_comb begin
    ov_idx = '0;
    oc_idx = '0;
    for (int i = N_RAILS - 1; i >= 0; i--) begin
      if (ov_flag[i]) ov_idx = RW'(i);
      if (oc_flag[i]) oc_idx = RW'(i);
    end
  end

  always_comb begin
    trip_cause = FC_NONE;
    trip_rail  = '0;
    if (!door_closed) begin
      trip_cause = FC_DOOR;
    end else if (|ov_flag) begin
      trip_cause = FC_OVERV;
      trip_rail  = ov_idx;
    end else if (|oc_flag) begin
      trip_cause = FC_OVERC;
      trip_rail  = oc_idx;
    end
  end

  assign trip = (trip_cause != FC_NONE);

endmodule

// File: rtl/pwrseq_step_timer.sv
module pwrseq_step_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] count
);

  // saturating up-counter, restarted whenever the controller changes step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (clr)            count <= '0;
    else if (count != '1)    count <= count + W'(1);
  end

endmodule

// File: rtl/pwrseq_rail_ladder.sv
module pwrseq_rail_ladder #(
  parameter int N_RAILS = 3,
  parameter int RW      = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               kill,
  input  logic               first,
  input  logic               up,
  input  logic               down,
  output logic [N_RAILS-1:0] rail_en,
  output logic [RW-1:0]      top_idx,
  output logic [N_RAILS-1:0] top_oh
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rail_en <= '0;
    else if (kill)  rail_en <= '0;
    else if (first) rail_en <= N_RAILS'(1);
    else if (up)    rail_en <= (rail_en << 1) | N_RAILS'(1);
    else if (down)  rail_en <= rail_en >> 1;
  end

  assign top_oh = rail_en & ~(rail_en >> 1);

  always_comb begin
    top_idx = '0;
    for (int i = 0; i < N_RAILS; i++)
      if (top_oh[i]) top_idx = RW'(i);
  end

  // enables always form a contiguous run from the core rail upward
  assert_thermometer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((rail_en & (rail_en + N_RAILS'(1))) == '0));

  // power-up never turns on two rails in the same edge
  assert_one_rail_per_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(rail_en & ~$past(rail_en)) <= 1));

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int N_RAILS = 3,
  parameter int TO_W    = 8,
  parameter int SETTLE  = 4,
  localparam int RW     = (N_RAILS > 1) ? $clog2(N_RAILS) : 1,
  localparam int SW     = (SETTLE > 1) ? $clog2(SETTLE) : 1,
  localparam int CNT_W  = (TO_W > SW) ? TO_W : SW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_req,
  input  logic               stop_req,
  input  logic               fault_clr,
  input  logic               door_closed,
  input  logic [N_RAILS-1:0] pgood,
  input  logic [N_RAILS-1:0] ov_flag,
  input  logic [N_RAILS-1:0] oc_flag,
  input  logic [TO_W-1:0]    pg_timeout,
  output logic [N_RAILS-1:0] rail_en,
  output logic               measure_ok,
  output logic [2:0]         phase,
  output logic [2:0]         fault_cause,
  output logic [RW-1:0]      fault_rail
);

  phase_e             phase_q, phase_d;
  cause_e             fcause_q, latch_cause;
  logic [RW-1:0]      frail_q, latch_rail;
  logic               latch_en;

  logic               trip;
  cause_e             trip_cause;
  logic [RW-1:0]      trip_rail;

  logic               lad_kill, lad_first, lad_up, lad_down;
  logic [RW-1:0]      top_idx;
  logic [N_RAILS-1:0] top_oh;

  logic               tmr_clr;
  logic [CNT_W-1:0]   tmr;

  logic top_good, down_empty, settle_done, pg_expired;

  pwrseq_trip_arb #(.N_RAILS(N_RAILS), .RW(RW)) u_arb (
    .door_closed (door_closed),
    .ov_flag     (ov_flag),
    .oc_flag     (oc_flag),
    .trip        (trip),
    .trip_cause  (trip_cause),
    .trip_rail   (trip_rail)
  );

  pwrseq_rail_ladder #(.N_RAILS(N_RAILS), .RW(RW)) u_ladder (
    .clk     (clk),
    .rst_n   (rst_n),
    .kill    (lad_kill),
    .first   (lad_first),
    .up      (lad_up),
    .down    (lad_down),
    .rail_en (rail_en),
    .top_idx (top_idx),
    .top_oh  (top_oh)
  );

  pwrseq_step_timer #(.W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .count (tmr)
  );

  assign top_good    = |(pgood & top_oh);
  assign down_empty  = ((rail_en >> 1) == '0);
  assign settle_done = (tmr == CNT_W'(SETTLE - 1));
  assign pg_expired  = (tmr == (CNT_W'(pg_timeout) - CNT_W'(1)));

  always_comb begin
    phase_d     = phase_q;
    lad_kill    = 1'b0;
    lad_first   = 1'b0;
    lad_up      = 1'b0;
    lad_down    = 1'b0;
    tmr_clr     = 1'b0;
    latch_en    = 1'b0;
    latch_cause = trip_cause;
    latch_rail  = trip_rail;

    if (phase_q != PH_IDLE && trip) begin
      // interlock or protection: drop everything at once
      lad_kill = 1'b1;
      latch_en = 1'b1;
      phase_d  = PH_IDLE;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start_req && door_closed && fcause_q == FC_NONE) begin
            lad_first = 1'b1;
            tmr_clr   = 1'b1;
            phase_d   = PH_PRECHARGE;
          end
        end
        PH_PRECHARGE: begin
          if (stop_req) begin
            lad_down = 1'b1;
            tmr_clr  = 1'b1;
            phase_d  = down_empty ? PH_IDLE : PH_RAMPDOWN;
          end else if (top_good) begin
            tmr_clr = 1'b1;
            if (rail_en[N_RAILS-1]) phase_d = PH_ON;
            else                    lad_up  = 1'b1;
          end else if (pg_expired) begin
            lad_kill    = 1'b1;
            latch_en    = 1'b1;
            latch_cause = FC_TIMEOUT;
            latch_rail  = top_idx;
            phase_d     = PH_IDLE;
          end
        end
        PH_ON, PH_MEASURE: begin
          if (stop_req) begin
            lad_down = 1'b1;
            tmr_clr  = 1'b1;
            phase_d  = PH_RAMPDOWN;
          end else if (phase_q == PH_ON && settle_done) begin
            tmr_clr = 1'b1;
            phase_d = PH_MEASURE;
          end
        end
        PH_RAMPDOWN: begin
          if (settle_done) begin
            lad_down = 1'b1;
            tmr_clr  = 1'b1;
            if (down_empty) phase_d = PH_IDLE;
          end
        end
        default: begin
          lad_kill = 1'b1;
          phase_d  = PH_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      fcause_q <= FC_NONE;
      frail_q  <= '0;
    end else begin
      phase_q <= phase_d;
      if (latch_en) begin
        fcause_q <= latch_cause;
        frail_q  <= latch_rail;
      end else if (fault_clr && phase_q == PH_IDLE) begin
        fcause_q <= FC_NONE;
        frail_q  <= '0;
      end
    end
  end

  assign phase       = phase_q;
  assign measure_ok  = (phase_q == PH_MEASURE);
  assign fault_cause = fcause_q;
  assign fault_rail  = frail_q;

  // permission is never granted with any rail still down
  assert_measure_rails_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    measure_ok |-> (&rail_en));

  // a newly enabled rail above the core needs its lower neighbour good
  assert_wait_lower_good_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((((rail_en & ~$past(rail_en)) >> 1) & ~$past(pgood)) == '0));

  assert_door_shutdown_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!door_closed && phase_q != PH_IDLE) |=> (rail_en == '0 && phase_q == PH_IDLE));

  assert_protect_shutdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (((|ov_flag) || (|oc_flag)) && phase_q != PH_IDLE) |=> (rail_en == '0));

  assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fcause_q != FC_NONE && !(fault_clr && phase_q == PH_IDLE))
      |=> (fcause_q == $past(fcause_q) && frail_q == $past(frail_q)));

  assert_start_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && (fcause_q != FC_NONE || !door_closed)) |=> (phase_q == PH_IDLE));

endmodule

// File: tb/pwrseq_ctrl_tb.sv
`timescale 1ns/1ps
module pwrseq_ctrl_tb;

  localparam int N  = 3;
  localparam int ST = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0, stop_req = 1'b0, fault_clr = 1'b0, door_closed = 1'b1;
  logic [N-1:0] pgood = '0, ov_flag = '0, oc_flag = '0;
  logic [7:0]   pg_timeout = 8'd6;
  logic [N-1:0] rail_en;
  logic         measure_ok;
  logic [2:0]   phase, fault_cause;
  logic [1:0]   fault_rail;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;

  typedef struct {
    int         due;
    logic [2:0] en;
    logic [2:0] ph;
    logic       mo;
    logic [2:0] cs;
    logic [1:0] rl;
    string      tag;
  } snap_t;

  snap_t sbq[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwrseq_ctrl #(.N_RAILS(N), .TO_W(8), .SETTLE(ST)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
    .fault_clr(fault_clr), .door_closed(door_closed), .pgood(pgood),
    .ov_flag(ov_flag), .oc_flag(oc_flag), .pg_timeout(pg_timeout),
    .rail_en(rail_en), .measure_ok(measure_ok), .phase(phase),
    .fault_cause(fault_cause), .fault_rail(fault_rail)
  );

  // driver side: file an expected snapshot d cycles from now
  task automatic ex(input int d, input logic [2:0] en, input logic [2:0] ph,
                    input logic mo, input logic [2:0] cs, input logic [1:0] rl,
                    input string tag);
    snap_t s;
    s.due = cyc + d; s.en = en; s.ph = ph; s.mo = mo; s.cs = cs; s.rl = rl; s.tag = tag;
    sbq.push_back(s);
  endtask

  task automatic nc();
    @(negedge clk);
  endtask

  // monitor side: compare every snapshot due in this cycle
  always @(negedge clk) begin
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].due == cyc) begin
        n_tests++;
        if (rail_en !== sbq[i].en || phase !== sbq[i].ph || measure_ok !== sbq[i].mo ||
            fault_cause !== sbq[i].cs || fault_rail !== sbq[i].rl) begin
          n_fail++;
          $display("FAIL %s: got en=%b ph=%0d mo=%b cause=%0d rail=%0d, expected en=%b ph=%0d mo=%b cause=%0d rail=%0d",
                   sbq[i].tag, rail_en, phase, measure_ok, fault_cause, fault_rail,
                   sbq[i].en, sbq[i].ph, sbq[i].mo, sbq[i].cs, sbq[i].rl);
        end
        sbq.delete(i);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) nc();
    rst_n = 1'b1;
    ex(1, 3'b000, 3'd0, 1'b0, 3'd0, 2'd0, "R1 reset state idle");

    // normal bring-up, measure, reverse ramp-down
    nc(); start_req = 1'b1;
    ex(1, 3'b001, 3'd1, 1'b0, 3'd0, 2'd0, "R2 core rail first");
    nc(); start_req = 1'b0; pgood = 3'b001;
    ex(1, 3'b011, 3'd1, 1'b0, 3'd0, 2'd0, "R2 io after core good");
    nc(); pgood = 3'b011;
    ex(1, 3'b111, 3'd1, 1'b0, 3'd0, 2'd0, "R2 rf after io good");
    nc(); pgood = 3'b111;
    ex(1, 3'b111, 3'd2, 1'b0, 3'd0, 2'd0, "R1 on phase entered");
    ex(4, 3'b111, 3'd2, 1'b0, 3'd0, 2'd0, "R3 no permission in on dwell");
    ex(5, 3'b111, 3'd3, 1'b1, 3'd0, 2'd0, "R3 measure permitted");
    repeat (6) nc();
    stop_req = 1'b1;
    ex(1, 3'b011, 3'd4, 1'b0, 3'd0, 2'd0, "R7 rf dropped first");
    ex(4, 3'b011, 3'd4, 1'b0, 3'd0, 2'd0, "R7 settle gap held");
    ex(5, 3'b001, 3'd4, 1'b0, 3'd0, 2'd0, "R7 io dropped second");
    ex(8, 3'b001, 3'd4, 1'b0, 3'd0, 2'd0, "R7 core held through gap");
    ex(9, 3'b000, 3'd0, 1'b0, 3'd0, 2'd0, "R7 core last then idle");
    nc(); stop_req = 1'b0; pgood = '0;
    repeat (10) nc();

    // stop while only the core rail is up
    start_req = 1'b1;
    ex(1, 3'b001, 3'd1, 1'b0, 3'd0, 2'd0, "R1 precharge entry");
    nc(); start_req = 1'b0; stop_req = 1'b1;
    ex(1, 3'b000, 3'd0, 1'b0, 3'd0, 2'd0, "R7 stop in precharge to idle");
    nc(); stop_req = 1'b0;
    repeat (2) nc();

    // io rail never reports good
    pgood = 3'b001; start_req = 1'b1;
    ex(1, 3'b001, 3'd1, 1'b0, 3'd0, 2'd0, "R2 core rail first again");
    ex(2, 3'b011, 3'd1, 1'b0, 3'd0, 2'd0, "R2 io enabled on core good");
    ex(7, 3'b011, 3'd1, 1'b0, 3'd0, 2'd0, "R6 still waiting before timeout");
    ex(8, 3'b000, 3'd0, 1'b0, 3'd4, 2'd1, "R6 timeout on rail 1");
    nc(); start_req = 1'b0;
    repeat (8) nc();
    start_req = 1'b1;
    ex(1, 3'b000, 3'd0, 1'b0, 3'd4, 2'd1, "R9 start ignored with fault");
    ex(2, 3'b000, 3'd0, 1'b0, 3'd4, 2'd1, "R8 fault sticky");
    nc(); start_req = 1'b0;
    nc(); fault_clr = 1'b1;
    ex(1, 3'b000, 3'd0, 1'b0, 3'd0, 2'd0, "R8 clear in idle");
    nc(); fault_clr = 1'b0; pgood = 3'b111;
    nc();

    // door opens during precharge
    start_req = 1'b1;
    nc(); start_req = 1'b0;
    nc(); nc();
    door_closed = 1'b0;
    ex(1, 3'b000, 3'd0, 1'b0, 3'd1, 2'd0, "R4 door shutdown");
    nc(); door_closed = 1'b1;
    nc(); fault_clr = 1'b1;
    ex(1, 3'b000, 3'd0, 1'b0, 3'd0, 2'd0, "R8 door fault cleared");
    nc(); fault_clr = 1'b0;
    door_closed = 1'b0; start_req = 1'b1;
    ex(1, 3'b000, 3'd0, 1'b0, 3'd0, 2'd0, "R9 start ignored door open");
    ex(3, 3'b000, 3'd0, 1'b0, 3'd0, 2'd0, "R4 open door in idle no fault");
    nc(); start_req = 1'b0;
    nc(); nc(); door_closed = 1'b1;
    nc();

    // protection flags: ignored idle, prioritised when powered
    ov_flag = 3'b111;
    ex(1, 3'b000, 3'd0, 1'b0, 3'd0, 2'd0, "R5 flags ignored in idle");
    nc(); ov_flag = '0;
    nc(); start_req = 1'b1;
    ex(8, 3'b111, 3'd3, 1'b1, 3'd0, 2'd0, "R1 measure reached again");
    nc(); start_req = 1'b0;
    repeat (8) nc();
    ov_flag = 3'b010; oc_flag = 3'b100;
    ex(1, 3'b000, 3'd0, 1'b0, 3'd2, 2'd1, "R5 overvoltage beats overcurrent");
    nc(); ov_flag = '0; oc_flag = '0;
    nc(); fault_clr = 1'b1;
    ex(1, 3'b000, 3'd0, 1'b0, 3'd0, 2'd0, "R8 ov fault cleared");
    nc(); fault_clr = 1'b0; pgood = 3'b001;
    nc(); start_req = 1'b1;
    nc(); start_req = 1'b0;
    nc();
    oc_flag = 3'b110;
    ex(1, 3'b000, 3'd0, 1'b0, 3'd3, 2'd1, "R5 overcurrent lowest rail named");
    nc(); oc_flag = '0;
    repeat (5) nc();

    if (sbq.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: got %0d pending, expected 0", sbq.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule